// File: doc/BRIEF.md
# Two-Wire Register Slave with Clock-Snapshot Freeze

This block is a two-wire (I2C) slave that fronts a 64-byte register space. Its lowest eight bytes hold clock and calendar values. An external timekeeping counter supplies them as one parallel snapshot with an update strobe. The other bytes are plain storage. A bus master sets a byte pointer with a write transaction, then writes a run of bytes or reads them back in sequence. The pointer advances by itself.

While the slave is addressed and its pointer sits on one of the clock bytes, it does not copy new snapshots into those bytes. A multi-byte read of the time therefore returns one consistent set of values. The newest snapshot that arrived in that interval is applied once, when the pointer leaves the clock range or the master ends the transaction with STOP.

Both bus lines are brought into the system clock domain through two-flop synchronisers. All protocol decisions are taken in that domain. The slave drives SDA only as an open-drain pull-down enable, and it changes that enable only while SCL is low.

Top module: `i2c_rtc_regslave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `DEV_ADDR` (default 7'h68) by pulling SDA low through the ninth clock; bit 0 of that byte selects a read (1) or a write (0). With any other address it leaves SDA released, including for the data bytes that follow, until the next START or STOP. Its pointer and storage stay unchanged.
- R2: In a write transaction, the first byte after the address is loaded into the 6-bit pointer. Each later byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R3: After a repeated START and a read address, the slave sends the byte at the pointer, most significant bit first.
- R4: During a read, the pointer advances only when the master acknowledges (SDA low on the ninth clock), and the next byte follows. On a master not-acknowledge the slave releases SDA, keeps the pointer, and waits for START or STOP.
- R5: A read address sent straight after START, with no pointer write, starts reading at the pointer left by the previous transaction.
- R6: The pointer wraps from 3Fh to 00h.
- R7: When no freeze is in force, a strobe on `live_stb` copies `live_time[8i+7:8i]` into register i for i = 0..7. The copy is visible on `reg_image` after the next clock edge.
- R8: While the slave is addressed and the pointer is in 00h–07h, strobes do not change registers 0–7.
- R9: The freeze ends on STOP or when the pointer moves to 08h or above. The last snapshot strobed during the freeze is then applied once.
- R10: `sda_pull` changes only while the synchronised SCL is low.
- R11: After reset, SDA is released, every register reads zero and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| live_time | input | 64 | Live clock snapshot; byte i feeds register i |
| live_stb | input | 1 | One-cycle strobe marking a new snapshot |
| sda_pull | output | 1 | 1 pulls SDA low |
| reg_image | output | 512 | Register contents; register i at bits 8i+7:8i |

## Verification
The hardest case to reach from the ports is a snapshot that arrives while a read sits on a clock byte. It must stay hidden while reading continues. It must then appear exactly once, at the right moment, whether the freeze ends on STOP or because a master acknowledge carries the pointer from 07h to 08h. The bench injects strobes between bytes of an open read, issues more than one of them to confirm that only the newest wins, and checks the register image before and after the pointer crosses out of range. Wrap-around, current-address reads and a foreign address are driven through the same bit-level master tasks.

// File: rtl/i2c_rtc_pkg.sv
package i2c_rtc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_IGNORE,
        ST_ACK,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_MACK
    } slv_state_t;

    typedef enum logic [1:0] {
        AK_ADDR_W,
        AK_ADDR_R,
        AK_PTR,
        AK_DATA
    } ack_kind_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] r, input logic b);
        return {r[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_rtc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_in;
                    sda_ff <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_in};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl   = scl_s;
        evt.sda   = sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
    import i2c_rtc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         PTR_W    = 6,
    parameter int         CLK_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              freeze
);

    localparam logic [PTR_W-1:0] CLK_LIM = PTR_W'(CLK_REGS);

    slv_state_t        state;
    ack_kind_t         kind;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [2:0]        bcnt;
    logic [2:0]        tcnt;
    logic              bdone;
    logic              sel;
    logic              macked;
    logic              rx_phase;

    assign rx_phase = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
    assign wr_addr  = ptr;
    assign wr_data  = shreg;
    assign freeze   = sel && (ptr < CLK_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= AK_ADDR_W;
            shreg    <= '0;
            tx       <= '0;
            bcnt     <= '0;
            tcnt     <= '0;
            bdone    <= 1'b0;
            sel      <= 1'b0;
            macked   <= 1'b0;
            sda_pull <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state    <= ST_ADDR;
                bcnt     <= '0;
                bdone    <= 1'b0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                sel      <= 1'b0;
                bdone    <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                if (rx_phase && evt.rise) begin
                    shreg <= shift_in(shreg, evt.sda);
                    bcnt  <= bcnt + 3'd1;
                    bdone <= (bcnt == 3'd7);
                end
                if (state == ST_MACK && evt.rise && !evt.sda) begin
                    ptr    <= ptr + 1'b1;
                    macked <= 1'b1;
                end
                if (evt.fall) begin
                    case (state)
                        ST_ADDR: if (bdone) begin
                            bdone <= 1'b0;
                            if (shreg[7:1] == DEV_ADDR) begin
                                sel      <= 1'b1;
                                sda_pull <= 1'b1;
                                kind     <= shreg[0] ? AK_ADDR_R : AK_ADDR_W;
                                state    <= ST_ACK;
                            end else begin
                                sel   <= 1'b0;
                                state <= ST_IGNORE;
                            end
                        end
                        ST_PTR: if (bdone) begin
                            bdone    <= 1'b0;
                            ptr      <= shreg[PTR_W-1:0];
                            sda_pull <= 1'b1;
                            kind     <= AK_PTR;
                            state    <= ST_ACK;
                        end
                        ST_WDATA: if (bdone) begin
                            bdone    <= 1'b0;
                            wr_en    <= 1'b1;
                            sda_pull <= 1'b1;
                            kind     <= AK_DATA;
                            state    <= ST_ACK;
                        end
                        ST_ACK: begin
                            sda_pull <= 1'b0;
                            bcnt     <= '0;
                            case (kind)
                                AK_ADDR_W: state <= ST_PTR;
                                AK_PTR:    state <= ST_WDATA;
                                AK_DATA: begin
                                    ptr   <= ptr + 1'b1;
                                    state <= ST_WDATA;
                                end
                                default: begin
                                    tx       <= rd_data;
                                    tcnt     <= '0;
                                    sda_pull <= ~rd_data[7];
                                    state    <= ST_RDATA;
                                end
                            endcase
                        end
                        ST_RDATA: begin
                            if (tcnt == 3'd7) begin
                                sda_pull <= 1'b0;
                                macked   <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                sda_pull <= ~tx[3'd6 - tcnt];
                                tcnt     <= tcnt + 3'd1;
                            end
                        end
                        ST_MACK: begin
                            if (macked) begin
                                tx       <= rd_data;
                                tcnt     <= '0;
                                sda_pull <= ~rd_data[7];
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R10: the pull-down enable only moves while SCL is low
    a_r10_pull_when_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !$past(evt.scl));

    // R4: a master not-acknowledge leaves the pointer where it was
    a_r4_nack_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK && evt.rise && evt.sda) |=> (ptr == $past(ptr)));

    // R1: a foreign transaction never sees the pull-down
    a_r1_ignore_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_pull);

    // R3: the first bit placed on the bus is the byte's MSB
    a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDATA && $past(state) != ST_RDATA) |-> (sda_pull == !tx[7]));

    // R6: the pointer rolls over from its top value to zero
    a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && kind == AK_DATA && evt.fall && ptr == '1) |=> (ptr == '0));

endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
    import i2c_rtc_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int CLK_REGS = 8,
    parameter int AW       = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       freeze,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [AW-1:0]              rd_addr,
    input  logic [CLK_REGS*BYTE_W-1:0] live_time,
    input  logic                       live_stb,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [DEPTH*BYTE_W-1:0]    image
);

    logic [DEPTH-1:0][BYTE_W-1:0]  mem;
    logic [CLK_REGS*BYTE_W-1:0]    pend;
    logic                          pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem    <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else begin
            if (freeze) begin
                if (live_stb) begin
                    pend   <= live_time;
                    pend_v <= 1'b1;
                end
            end else if (live_stb || pend_v) begin
                for (int i = 0; i < CLK_REGS; i++) begin
                    mem[i] <= live_stb ? live_time[i*BYTE_W +: BYTE_W]
                                       : pend[i*BYTE_W +: BYTE_W];
                end
                pend_v <= 1'b0;
            end
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign image   = mem;

    // R8: clock bytes hold still while frozen and no bus write lands
    a_r8_clock_frozen: assert property (@(posedge clk) disable iff (rst)
        (freeze && !wr_en) |=> $stable(mem[CLK_REGS-1:0]));

    // R9: a held snapshot is released in a single cycle once the freeze ends
    a_r9_single_flush: assert property (@(posedge clk) disable iff (rst)
        (!freeze && pend_v) |=> !pend_v);

    // R7: an unfrozen strobe lands on the clock bytes at the next edge
    a_r7_live_copy: assert property (@(posedge clk) disable iff (rst)
        (!freeze && live_stb && !wr_en) |=> (mem[CLK_REGS-1:0] == $past(live_time)));

endmodule

// File: rtl/i2c_rtc_regslave.sv
module i2c_rtc_regslave
    import i2c_rtc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         DEPTH    = 64,
    parameter int         CLK_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic [CLK_REGS*BYTE_W-1:0] live_time,
    input  logic                       live_stb,
    output logic                       sda_pull,
    output logic [DEPTH*BYTE_W-1:0]    reg_image
);

    localparam int AW = $clog2(DEPTH);

    bus_evt_t          evt;
    logic [AW-1:0]     ptr;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              freeze;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_slave_engine #(
        .DEV_ADDR (DEV_ADDR),
        .PTR_W    (AW),
        .CLK_REGS (CLK_REGS)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rd_data  (rd_data),
        .sda_pull (sda_pull),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .freeze   (freeze)
    );

    rtc_reg_bank #(
        .DEPTH    (DEPTH),
        .CLK_REGS (CLK_REGS),
        .AW       (AW)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .freeze    (freeze),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (ptr),
        .live_time (live_time),
        .live_stb  (live_stb),
        .rd_data   (rd_data),
        .image     (reg_image)
    );

endmodule

// File: tb/i2c_rtc_regslave_bench.sv
module i2c_rtc_regslave_bench;

    localparam logic [6:0] DEV = 7'h68;
    localparam int Q = 6;
    localparam int H = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         live_stb = 1'b0;
    logic [63:0]  live_time = '0;
    logic         sda_pull;
    logic [511:0] img;
    logic         sda_line;

    assign sda_line = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    i2c_rtc_regslave u_i2c_rtc_regslave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .live_time (live_time),
        .live_stb  (live_stb),
        .sda_pull  (sda_pull),
        .reg_image (img)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int          r10_bad = 0;
    bit          cmp_en = 0;
    bit          done = 0;
    logic [7:0]  mdl [64];
    int          m_ptr = 0;
    bit          m_sel = 0;
    bit          m_pv = 0;
    logic [63:0] m_pend = '0;
    logic        pull_q = 1'b0;

    function automatic logic [511:0] mdl_img();
        logic [511:0] r;
        for (int i = 0; i < 64; i++) r[i*8 +: 8] = mdl[i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_img(input string tag);
        n_chk++;
        if (img !== mdl_img()) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, img, mdl_img());
        end
    endtask

    // reference comparison on every clock while the model is settled
    always @(negedge clk) begin
        if (cmp_en) begin
            n_chk++;
            if (img !== mdl_img()) begin
                n_err++;
                $display("FAIL R7/R9 per-clock image actual=%h expected=%h", img, mdl_img());
            end
        end
    end

    // R10 monitor: pull-down must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && sda_pull !== pull_q && m_scl) r10_bad++;
        pull_q = sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_apply(input logic [63:0] v);
        for (int i = 0; i < 8; i++) mdl[i] = v[i*8 +: 8];
    endtask

    task automatic m_settle();
        if (!(m_sel && m_ptr < 8) && m_pv) begin
            m_apply(m_pend);
            m_pv = 0;
        end
    endtask

    task automatic strobe(input logic [63:0] v);
        @(negedge clk);
        live_time = v;
        live_stb  = 1'b1;
        @(posedge clk);
        #1;
        live_stb = 1'b0;
        if (m_sel && m_ptr < 8) begin
            m_pend = v;
            m_pv   = 1;
        end else begin
            m_apply(v);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
        tick(4);
        m_sel = 0;
        m_settle();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0; tick(2);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(H/2);
        acked = !sda_line;
        tick(H/2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(H/2);
            b[i] = sda_line;
            tick(H/2);
            m_scl = 1'b0; tick(2);
        end
        m_sda = !ack; tick(Q);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    task automatic addr_phase(input bit rd, input string tag);
        bit a;
        send_byte({DEV, rd}, a);
        chk(a == 1'b1, tag, a, 1);
        if (a) m_sel = 1;
        m_settle();
    endtask

    task automatic ptr_phase(input logic [7:0] p, input string tag);
        bit a;
        send_byte(p, a);
        chk(a == 1'b1, tag, a, 1);
        m_ptr = p & 8'h3F;
        m_settle();
    endtask

    task automatic data_phase(input logic [7:0] d, input string tag);
        bit a;
        send_byte(d, a);
        chk(a == 1'b1, tag, a, 1);
        mdl[m_ptr] = d;
        m_ptr = (m_ptr + 1) % 64;
        m_settle();
    endtask

    task automatic read_phase(input bit ack, input string tag);
        logic [7:0] got;
        logic [7:0] exp;
        exp = mdl[m_ptr];
        recv_byte(ack, got);
        chk(got === exp, tag, got, exp);
        if (ack) begin
            m_ptr = (m_ptr + 1) % 64;
            m_settle();
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(3);

        // R11: reset state
        chk(sda_pull == 1'b0, "R11 sda released after reset", sda_pull, 0);
        chk_img("R11 registers zero after reset");
        cmp_en = 1;

        // R7: unfrozen strobe copies all clock bytes
        strobe(64'h0123_4567_89AB_CDEF);
        tick(1);
        chk(img[63:0] === 64'h0123_4567_89AB_CDEF, "R7 live copy", img[63:0], 64'h0123_4567_89AB_CDEF);

        // R1, R2: write transaction with pointer load and three bytes
        cmp_en = 0;
        bus_start();
        addr_phase(1'b0, "R1 write address ack");
        ptr_phase(8'h10, "R2 pointer byte ack");
        data_phase(8'hA5, "R2 data ack");
        data_phase(8'h3C, "R2 data ack");
        data_phase(8'h7E, "R2 data ack");
        bus_stop();
        chk_img("R2 written bytes stored");
        cmp_en = 1;

        // R3, R4: random read of three bytes, last not acknowledged
        cmp_en = 0;
        bus_start();
        addr_phase(1'b0, "R1 write address ack");
        ptr_phase(8'h10, "R2 pointer byte ack");
        bus_start();
        addr_phase(1'b1, "R3 read address ack");
        read_phase(1'b1, "R3 first byte at pointer");
        read_phase(1'b1, "R4 sequential byte after ack");
        read_phase(1'b0, "R4 third byte before nack");
        chk(sda_pull == 1'b0, "R4 released after nack", sda_pull, 0);
        bus_stop();
        cmp_en = 1;

        // R5, R4: current-address reads twice, nack keeps the pointer
        for (int k = 0; k < 2; k++) begin
            cmp_en = 0;
            bus_start();
            addr_phase(1'b1, "R5 current read address ack");
            read_phase(1'b0, "R5 current read from kept pointer");
            bus_stop();
            cmp_en = 1;
        end

        // R1: foreign address is ignored, pointer and storage untouched
        cmp_en = 0;
        bus_start();
        send_byte({7'h28, 1'b0}, a);
        chk(a == 1'b0, "R1 foreign address not acked", a, 0);
        send_byte(8'h20, a);
        chk(a == 1'b0, "R1 byte after foreign address not acked", a, 0);
        bus_stop();
        chk_img("R1 storage untouched by foreign write");
        bus_start();
        addr_phase(1'b1, "R1 read address ack");
        read_phase(1'b0, "R1 pointer untouched by foreign write");
        bus_stop();
        cmp_en = 1;

        // R6: pointer wraps from 3Fh to 00h
        cmp_en = 0;
        bus_start();
        addr_phase(1'b0, "R6 write address ack");
        ptr_phase(8'h3F, "R6 pointer ack");
        data_phase(8'h11, "R6 data at 3Fh");
        data_phase(8'h22, "R6 data at 00h after wrap");
        bus_stop();
        chk_img("R6 wrapped write placement");
        bus_start();
        addr_phase(1'b1, "R6 read address ack");
        read_phase(1'b0, "R6 pointer at 01h after wrap");
        bus_stop();
        cmp_en = 1;

        // R8, R9: freeze during a clock read, release on STOP with newest snapshot
        cmp_en = 0;
        bus_start();
        addr_phase(1'b0, "R8 write address ack");
        ptr_phase(8'h02, "R8 pointer in clock range");
        bus_start();
        addr_phase(1'b1, "R8 read address ack");
        strobe(64'h1111_2222_3333_4444);
        read_phase(1'b1, "R8 frozen byte 02h");
        strobe(64'h5555_6666_7777_8888);
        read_phase(1'b0, "R8 frozen byte 03h");
        tick(2);
        chk_img("R8 clock bytes held during freeze");
        bus_stop();
        tick(1);
        chk_img("R9 newest snapshot applied on STOP");
        chk(img[63:0] === 64'h5555_6666_7777_8888, "R9 latest snapshot wins", img[63:0], 64'h5555_6666_7777_8888);
        cmp_en = 1;

        // R9, R7: freeze ends when the pointer steps from 07h to 08h
        cmp_en = 0;
        bus_start();
        addr_phase(1'b0, "R9 write address ack");
        ptr_phase(8'h06, "R9 pointer at 06h");
        bus_start();
        addr_phase(1'b1, "R9 read address ack");
        strobe(64'h9999_AAAA_BBBB_CCCC);
        read_phase(1'b1, "R8 frozen byte 06h");
        tick(2);
        chk(img[63:0] === 64'h5555_6666_7777_8888, "R8 still held at 07h", img[63:0], 64'h5555_6666_7777_8888);
        read_phase(1'b1, "R8 frozen byte 07h");
        tick(2);
        chk_img("R9 snapshot applied on leaving clock range");
        chk(img[63:0] === 64'h9999_AAAA_BBBB_CCCC, "R9 flush on pointer exit", img[63:0], 64'h9999_AAAA_BBBB_CCCC);
        strobe(64'hDEAD_BEEF_0BAD_F00D);
        tick(1);
        chk(img[63:0] === 64'hDEAD_BEEF_0BAD_F00D, "R7 live copy with pointer at 08h", img[63:0], 64'hDEAD_BEEF_0BAD_F00D);
        read_phase(1'b0, "R4 byte 08h after ack");
        bus_stop();
        cmp_en = 1;
        tick(4);

        chk(r10_bad == 0, "R10 pull changes only with SCL low", r10_bad, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule